// File: doc/BRIEF.md
# Real-Time Monitor Word Serializer

This block puts four words from a data memory onto a single serial output so that they can be watched on a test pin. A rising edge on the synchronisation input starts a burst. The block reads the four words through a synchronous memory read port with one cycle of latency. It takes each word's address from its own programmable address slot, in slot order 0, 1, 2, 3.

Every word fills a fixed slot of 35 serial bit times. The slot holds a high flag bit, then the 32 data bits with the most significant bit first, then two low bits. Bit times advance only on cycles where the test tick input is high; this input acts as a clock enable in the system clock domain. The next word is fetched from memory while the current word is still shifting out, so the four slots follow each other with no gap. An enable input gates the whole function, and the output is low whenever no word is being shifted.

Top module: `rtm_serializer`

## Requirements
- R1: A burst starts only on a rising edge of `syncIn` seen while `enable` is high; holding `syncIn` high does not start a second burst. The first flag bit appears no later than the third tick counted from the cycle in which the edge is sampled.
- R2: Each burst makes exactly four single-cycle read requests (`memRdEn` high) with addresses `addrTable[0]`, `addrTable[1]`, `addrTable[2]`, `addrTable[3]` in that order. Read data is taken from `memRdData` one cycle after the request.
- R3: Each word occupies 35 consecutive ticks on `serOut`: one tick high (the flag), then data bits 31 down to 0, then two ticks low.
- R4: The four word slots of a burst are back to back: 140 consecutive ticks carry the whole burst, for any tick density up to one tick per cycle.
- R5: While `enable` is low no burst starts and no read is issued. Dropping `enable` during a burst aborts it, and `serOut` is low from the next cycle on.
- R6: `serOut` is low after reset, before a burst's first flag and after its last slot.
- R7: While `enable` is high, `serOut` changes only on clock edges where `testTick` is high.
- R8: A rising edge on `syncIn` during a burst is ignored and is not queued; no further burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Function enable |
| syncIn | input | 1 | Burst start; acts on its rising edge |
| testTick | input | 1 | Serial bit-time clock enable |
| addrTable | input | NUM_WORDS*ADDR_W | Read address for each word slot, slot i at bits [i*ADDR_W +: ADDR_W] |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | ADDR_W | Memory read address |
| memRdData | input | DATA_W | Memory read data, valid one cycle after the request |
| serOut | output | 1 | Serial monitor output |

## Verification
Bursts run with random addresses and memory contents at tick densities of every cycle, one cycle in two and one in five. A dense tick stream shows whether the prefetch keeps the slots gapless. Sparse ticks show whether the output holds still between bit times. Directed runs cover four cases: a sync level held high, an extra sync pulse in mid-burst, a sync pulse while disabled, and an abort. These separate edge detection from level detection, and ignoring an edge from queueing it.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  typedef struct packed {
    logic rdIssue;
    logic capture;
    logic loadShift;
    logic shiftOut;
    logic drvFlag;
    logic drvZero;
  } rtmStrobe_t;
endpackage

// File: rtl/rtm_control.sv
module rtm_control
  import rtm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int SLOT_LEN  = 35,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             syncIn,
  input  logic             testTick,
  output rtmStrobe_t       strb,
  output logic [SEL_W-1:0] rdSel
);
  localparam int POS_W = $clog2(SLOT_LEN);
  localparam int IDX_W = $clog2(NUM_WORDS + 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;

  ctlState_t        st;
  logic             syncQ;
  logic             capPend;
  logic             bufValid;
  logic [IDX_W-1:0] rdIdx;
  logic [SEL_W-1:0] wordCnt;
  logic [POS_W-1:0] slotPos;
  logic             rise;

  assign rise  = syncIn & ~syncQ;
  assign rdSel = SEL_W'(rdIdx);

  always_comb begin
    strb = '0;
    strb.capture = capPend;
    if (!enable) begin
      strb.drvZero = 1'b1;
    end else begin
      case (st)
        ST_IDLE: strb.rdIssue = rise;
        ST_RUN: begin
          if (testTick) begin
            if (slotPos == '0) begin
              if (bufValid) begin
                strb.loadShift = 1'b1;
                strb.drvFlag   = 1'b1;
                strb.rdIssue   = (rdIdx < IDX_W'(NUM_WORDS));
              end else begin
                strb.drvZero = 1'b1;
              end
            end else if (slotPos <= POS_W'(DATA_W)) begin
              strb.shiftOut = 1'b1;
            end else begin
              strb.drvZero = 1'b1;
            end
          end
        end
        default: strb.drvZero = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      syncQ    <= 1'b0;
      capPend  <= 1'b0;
      bufValid <= 1'b0;
      rdIdx    <= '0;
      wordCnt  <= '0;
      slotPos  <= '0;
    end else begin
      syncQ   <= syncIn;
      capPend <= strb.rdIssue;
      if (capPend) bufValid <= 1'b1;
      if (!enable) begin
        st       <= ST_IDLE;
        bufValid <= 1'b0;
        rdIdx    <= '0;
        wordCnt  <= '0;
        slotPos  <= '0;
      end else begin
        case (st)
          ST_IDLE: begin
            if (rise) begin
              st      <= ST_RUN;
              rdIdx   <= IDX_W'(1);
              wordCnt <= '0;
              slotPos <= '0;
            end
          end
          ST_RUN: begin
            if (testTick) begin
              if (slotPos == '0) begin
                if (bufValid) begin
                  bufValid <= 1'b0;
                  slotPos  <= POS_W'(1);
                  if (strb.rdIssue) rdIdx <= rdIdx + 1'b1;
                end
              end else if (slotPos == POS_W'(SLOT_LEN - 1)) begin
                slotPos <= '0;
                if (wordCnt == SEL_W'(NUM_WORDS - 1)) begin
                  st    <= ST_IDLE;
                  rdIdx <= '0;
                end else begin
                  wordCnt <= wordCnt + 1'b1;
                end
              end else begin
                slotPos <= slotPos + 1'b1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtm_datapath.sv
module rtm_datapath
  import rtm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 4,
  parameter int SEL_W     = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  rtmStrobe_t                        strb,
  input  logic [SEL_W-1:0]                  rdSel,
  input  logic [NUM_WORDS-1:0][ADDR_W-1:0]  addrTable,
  input  logic [DATA_W-1:0]                 memRdData,
  output logic                              memRdEn,
  output logic [ADDR_W-1:0]                 memRdAddr,
  output logic                              serOut
);
  logic [NUM_WORDS-1:0][ADDR_W-1:0] addrMasked;
  logic [DATA_W-1:0]                bufWord;
  logic [DATA_W-1:0]                shiftReg;

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_addrSel
    assign addrMasked[gi] = (rdSel == SEL_W'(gi)) ? addrTable[gi] : '0;
  end

  always_comb begin
    memRdAddr = '0;
    for (int i = 0; i < NUM_WORDS; i++) memRdAddr |= addrMasked[i];
  end

  assign memRdEn = strb.rdIssue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufWord  <= '0;
      shiftReg <= '0;
      serOut   <= 1'b0;
    end else begin
      if (strb.capture) bufWord <= memRdData;
      if (strb.loadShift) begin
        shiftReg <= bufWord;
      end else if (strb.shiftOut) begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
      if (strb.drvZero)       serOut <= 1'b0;
      else if (strb.drvFlag)  serOut <= 1'b1;
      else if (strb.shiftOut) serOut <= shiftReg[DATA_W-1];
    end
  end
endmodule

// File: rtl/rtm_serializer.sv
module rtm_serializer
  import rtm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 4,
  parameter int TRAIL_LEN = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              enable,
  input  logic                              syncIn,
  input  logic                              testTick,
  input  logic [NUM_WORDS-1:0][ADDR_W-1:0]  addrTable,
  output logic                              memRdEn,
  output logic [ADDR_W-1:0]                 memRdAddr,
  input  logic [DATA_W-1:0]                 memRdData,
  output logic                              serOut
);
  localparam int SLOT_LEN = 1 + DATA_W + TRAIL_LEN;
  localparam int SEL_W    = $clog2(NUM_WORDS);

  rtmStrobe_t       strb;
  logic [SEL_W-1:0] rdSel;

  rtm_control #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .SLOT_LEN(SLOT_LEN), .SEL_W(SEL_W)
  ) i_control (
    .clk(clk), .rstN(rstN), .enable(enable), .syncIn(syncIn),
    .testTick(testTick), .strb(strb), .rdSel(rdSel)
  );

  rtm_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .SEL_W(SEL_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel),
    .addrTable(addrTable), .memRdData(memRdData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .serOut(serOut)
  );
endmodule

// File: rtl/rtm_serializer_chk.sv
module rtm_serializer_chk #(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 4
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              enable,
  input logic                              syncIn,
  input logic                              testTick,
  input logic [NUM_WORDS-1:0][ADDR_W-1:0]  addrTable,
  input logic                              memRdEn,
  input logic [ADDR_W-1:0]                 memRdAddr,
  input logic                              serOut
);
  localparam int SEL_W = $clog2(NUM_WORDS);

  logic             syncPrev;
  logic [SEL_W-1:0] rdNumExp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      rdNumExp <= '0;
    end else begin
      syncPrev <= syncIn;
      if (!enable) rdNumExp <= '0;
      else if (memRdEn) rdNumExp <= (rdNumExp == SEL_W'(NUM_WORDS - 1)) ? '0 : rdNumExp + 1'b1;
    end
  end

  a_r1_start_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && rdNumExp == '0) |-> (syncIn && !syncPrev));

  a_r2_read_order: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memRdAddr == addrTable[rdNumExp]));

  a_r5_no_read_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !memRdEn);

  a_r5_low_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !serOut);

  a_r7_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !testTick) |=> $stable(serOut));
endmodule

bind rtm_serializer rtm_serializer_chk #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) i_chk (.*);

// File: tb/test_rtm_serializer.sv
module test_rtm_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NW = 4;
  localparam int SLOT = 35;
  localparam int LOGLEN = 200;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              syncIn = 1'b0;
  logic              testTick = 1'b0;
  logic [NW-1:0][AW-1:0] addrTable = '0;
  logic              memRdEn;
  logic [AW-1:0]     memRdAddr;
  logic [DW-1:0]     memRdData = '0;
  logic              serOut;

  logic [DW-1:0] mem [256];
  logic          tickLog [$];
  logic [AW-1:0] rdLog [$];
  int checkCnt = 0;
  int failCnt = 0;
  int r7Err = 0;
  bit done = 0;
  bit lastTick = 0;
  bit lastEn = 0;
  logic prevOut = 1'b0;
  int dens = 100;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtm_serializer i_rtm_serializer (
    .clk(clk), .rstN(rstN), .enable(enable), .syncIn(syncIn),
    .testTick(testTick), .addrTable(addrTable), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .serOut(serOut)
  );

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= mem[memRdAddr];
      rdLog.push_back(memRdAddr);
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic expBit(int w, int p);
    if (p == 0) return 1'b1;
    if (p <= DW) return mem[addrTable[w]][DW - p];
    return 1'b0;
  endfunction

  task automatic step();
    logic cur;
    @(negedge clk);
    cur = serOut;
    if (lastTick) tickLog.push_back(cur);
    else if (lastEn && cur !== prevOut) r7Err++;
    prevOut = cur;
    testTick = ($urandom_range(99) < dens);
    lastTick = testTick;
    lastEn = enable;
  endtask

  task automatic randomizeSetup();
    for (int i = 0; i < NW; i++) begin
      addrTable[i] = AW'($urandom_range(255));
      mem[addrTable[i]] = $urandom();
    end
  endtask

  // mode: 0 normal pulse, 1 hold sync high, 2 extra pulse mid-burst
  task automatic runBurst(int mode, string tag);
    int s;
    bit ok;
    randomizeSetup();
    tickLog.delete();
    rdLog.delete();
    r7Err = 0;
    syncIn = 1'b1;
    while (tickLog.size() < LOGLEN) begin
      step();
      if (mode != 1 && tickLog.size() == 3) syncIn = 1'b0;
      if (mode == 2 && tickLog.size() == 60) syncIn = 1'b1;
      if (mode == 2 && tickLog.size() == 62) syncIn = 1'b0;
    end
    syncIn = 1'b0;
    s = -1;
    foreach (tickLog[i]) if (s < 0 && tickLog[i] === 1'b1) s = i;
    chk(s >= 0 && s <= 2, "R1", {tag, " first flag tick index"}, s, 2);
    if (s < 0) s = 0;
    ok = 1;
    for (int i = 0; i < s; i++) if (tickLog[i] !== 1'b0) ok = 0;
    chk(ok, "R6", {tag, " low before flag"}, 0, 0);
    for (int w = 0; w < NW; w++) begin
      ok = 1;
      for (int p = 0; p < SLOT; p++)
        if (tickLog[s + w*SLOT + p] !== expBit(w, p)) ok = 0;
      chk(ok, "R3", {tag, " word slot framing/data"}, w, mem[addrTable[w]]);
    end
    ok = 1;
    for (int i = s + NW*SLOT; i < LOGLEN; i++) if (tickLog[i] !== 1'b0) ok = 0;
    chk(ok, (mode == 0) ? "R6" : (mode == 1) ? "R1" : "R8", {tag, " low after burst"}, 0, 0);
    chk(rdLog.size() == NW, "R2", {tag, " read count"}, rdLog.size(), NW);
    for (int i = 0; i < NW && i < rdLog.size(); i++)
      chk(rdLog[i] == addrTable[i], "R2", {tag, " read address order"}, rdLog[i], addrTable[i]);
    chk(r7Err == 0, "R7", {tag, " output stable without tick"}, r7Err, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) step();
    chk(serOut === 1'b0 && memRdEn === 1'b0, "R6", "reset state", {serOut, memRdEn}, 0);
    rstN = 1'b1;
    enable = 1'b1;
    repeat (3) step();

    dens = 100; runBurst(0, "dense");
    chk(1, "R4", "dense ticks back-to-back (checked by slot offsets)", 0, 0);
    dens = 50;  runBurst(0, "half");
    dens = 20;  runBurst(0, "sparse");
    dens = 100; runBurst(1, "held sync");
    repeat (5) step();
    dens = 40;  runBurst(2, "mid-burst sync");
    dens = 100; runBurst(2, "mid-burst sync dense");

    // R5: disabled, sync pulse ignored
    enable = 1'b0;
    tickLog.delete(); rdLog.delete();
    syncIn = 1'b1; repeat (3) step(); syncIn = 1'b0;
    repeat (300) step();
    chk(rdLog.size() == 0, "R5", "no read while disabled", rdLog.size(), 0);
    begin
      bit ok = 1;
      foreach (tickLog[i]) if (tickLog[i] !== 1'b0) ok = 0;
      chk(ok, "R5", "output low while disabled", 0, 0);
    end

    // R5: abort mid-burst
    enable = 1'b1; repeat (3) step();
    dens = 100;
    randomizeSetup();
    tickLog.delete(); rdLog.delete();
    syncIn = 1'b1;
    while (tickLog.size() < 40) begin
      step();
      if (tickLog.size() == 3) syncIn = 1'b0;
    end
    syncIn = 1'b0;
    enable = 1'b0;
    step();
    chk(serOut === 1'b0, "R5", "abort drives output low", serOut, 0);
    tickLog.delete();
    repeat (60) step();
    begin
      bit ok = 1;
      foreach (tickLog[i]) if (tickLog[i] !== 1'b0) ok = 0;
      chk(ok, "R5", "stays low after abort", 0, 0);
    end
    enable = 1'b1; repeat (3) step();
    dens = 70; runBurst(0, "after abort");

    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule